// File: doc/BRIEF.md
# Rendering scroll address sequencer

This block walks the current video-memory address through the updates that a background tile fetch pipeline makes while a frame is drawn. It contains the raster position counters: 341 dots on each line, and a configurable number of lines with the last line used as the pre-render line. On each rendering line it steps the 15-bit current address at fixed dots. It advances the tile column once per fetched tile and advances the row once at the end of the fetch window. It also reloads the horizontal fields, and on the pre-render line the vertical fields, from a temporary address that the register front end supplies.

The address layout is fixed because the fetch logic decodes it. Bits [4:0] hold the coarse X tile column and bits [9:5] hold the coarse Y tile row. Bit 10 selects the horizontal nametable, bit 11 selects the vertical nametable, and bits [14:12] hold the fine Y pixel row. All updates are gated by a rendering-enable input. With rendering off, or on lines that are neither visible nor pre-render, the address holds its value. There is no data stream at the edges, so every pin is a plain level signal.

Top module: `scroll_addr_seq`

## Requirements
- R1: While rst_n is low the dot counter, the line counter and cur_addr are all zero, and they are still zero in the first cycle after release.
- R2: The dot counter counts 0 to 340 and then returns to 0. The line counter advances only when the dot counter wraps, and it goes from LINES-1 back to 0. A rendering line is any line below VISIBLE_LINES, plus the pre-render line LINES-1.
- R3: On a rendering line with render_en high, the clock edge taken while dot is 8, 16, ... 248, 328 or 336 increments coarse X (bits [4:0]) and leaves bits [14:11] and [9:5] unchanged.
- R4: A coarse X increment from 31 gives 0 and inverts bit 10.
- R5: The edge taken at dot 256 increments fine Y (bits [14:12]). From 7, fine Y wraps to 0 and coarse Y (bits [9:5]) steps instead.
- R6: When coarse Y steps, 29 wraps to 0 and inverts bit 11, 31 wraps to 0 and leaves bit 11 unchanged, and any other value increments.
- R7: The edge taken at dot 257 copies bit 10 and bits [4:0] of tmp_addr into cur_addr and keeps the other bits.
- R8: On the pre-render line, each edge taken at dots 280 to 304 copies bits [14:11] and [9:5] of tmp_addr and keeps bit 10 and bits [4:0].
- R9: cur_addr does not change when render_en is low, on non-rendering lines, or at any dot not named in R3, R5, R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| render_en | input | 1 | Enables the address updates |
| tmp_addr | input | 15 | Temporary address, the source for the reloads |
| dot | output | 9 | Current dot within the line |
| line | output | $clog2(LINES) | Current line within the frame |
| cur_addr | output | 15 | Current video-memory address |

## Verification
The hardest cases to reach are the two coarse Y wraps at 29 and 31. They need fine Y at 7 together with a chosen coarse Y, and those fields can only be loaded through the pre-render copy of the previous frame. The bench shortens the frame through the line-count parameters so that many frames fit in a run. It places fine Y 7 with coarse Y 29 or 31 on tmp_addr before the pre-render copy window, both in directed frames and at random in later frames. Random toggling of render_en in the middle of a line covers updates that are skipped at arbitrary dots.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int ADDR_W   = 15;
  localparam int DOT_W    = 9;
  localparam int LINE_DOTS = 341;

  typedef logic [ADDR_W-1:0] vaddr_t;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_STEP_X,
    OP_STEP_Y,
    OP_LOAD_H,
    OP_LOAD_V
  } addr_op_e;

  // coarse X with carry into the horizontal nametable bit
  function automatic vaddr_t step_col(input vaddr_t a);
    vaddr_t r;
    r = a;
    if (a[4:0] == 5'd31) begin
      r[4:0] = 5'd0;
      r[10]  = ~a[10];
    end else begin
      r[4:0] = a[4:0] + 5'd1;
    end
    return r;
  endfunction

  // fine Y, then coarse Y with the two distinct wrap rules
  function automatic vaddr_t step_row(input vaddr_t a);
    vaddr_t r;
    r = a;
    if (a[14:12] != 3'd7) begin
      r[14:12] = a[14:12] + 3'd1;
    end else begin
      r[14:12] = 3'd0;
      case (a[9:5])
        5'd29: begin r[9:5] = 5'd0; r[11] = ~a[11]; end
        5'd31: r[9:5] = 5'd0;
        default: r[9:5] = a[9:5] + 5'd1;
      endcase
    end
    return r;
  endfunction

  function automatic vaddr_t load_horiz(input vaddr_t a, input vaddr_t t);
    vaddr_t r;
    r = a;
    r[10]  = t[10];
    r[4:0] = t[4:0];
    return r;
  endfunction

  function automatic vaddr_t load_vert(input vaddr_t a, input vaddr_t t);
    vaddr_t r;
    r = a;
    r[14:11] = t[14:11];
    r[9:5]   = t[9:5];
    return r;
  endfunction
endpackage

// File: rtl/scroll_raster_counter.sv
module scroll_raster_counter
  import scroll_pkg::*;
#(
  parameter int LINES = 262,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line
);
  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(LINE_DOTS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot  <= '0;
      line <= '0;
    end else if (dot == DOT_LAST) begin
      dot  <= '0;
      line <= (line == LINE_LAST) ? '0 : line + 1'b1;
    end else begin
      dot <= dot + 1'b1;
    end
  end

  // R2: counter ranges and line stepping
  a_r2_dot_range: assert property (@(posedge clk) disable iff (!rst_n)
    dot <= DOT_LAST);
  a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dot != DOT_LAST |=> line == $past(line));
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == DOT_LAST && line == LINE_LAST) |=> (dot == '0 && line == '0));
endmodule

// File: rtl/scroll_op_decoder.sv
module scroll_op_decoder
  import scroll_pkg::*;
#(
  parameter int VISIBLE_LINES = 240,
  parameter int LINES = 262,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              render_en,
  output addr_op_e          op
);
  localparam logic [LINE_W-1:0] PRE_LINE = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] VIS_END  = LINE_W'(VISIBLE_LINES);

  logic draw_line;
  logic tile_edge;
  logic vert_window;

  always_comb begin
    draw_line   = (line < VIS_END) || (line == PRE_LINE);
    tile_edge   = ((dot[2:0] == 3'd0) && (dot != '0) && (dot < 9'd256)) ||
                  (dot == 9'd328) || (dot == 9'd336);
    vert_window = (line == PRE_LINE) && (dot >= 9'd280) && (dot <= 9'd304);
    op = OP_HOLD;
    if (render_en && draw_line) begin
      if (dot == 9'd256)      op = OP_STEP_Y;
      else if (dot == 9'd257) op = OP_LOAD_H;
      else if (tile_edge)     op = OP_STEP_X;
      else if (vert_window)   op = OP_LOAD_V;
    end
  end
endmodule

// File: rtl/scroll_addr_reg.sv
module scroll_addr_reg
  import scroll_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  addr_op_e op,
  input  vaddr_t   tmp_addr,
  output vaddr_t   cur_addr
);
  vaddr_t next_addr;

  always_comb begin
    unique case (op)
      OP_STEP_X: next_addr = step_col(cur_addr);
      OP_STEP_Y: next_addr = step_row(cur_addr);
      OP_LOAD_H: next_addr = load_horiz(cur_addr, tmp_addr);
      OP_LOAD_V: next_addr = load_vert(cur_addr, tmp_addr);
      default:   next_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_addr <= '0;
    else        cur_addr <= next_addr;
  end

  // R9: a hold decision leaves the register untouched
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(cur_addr));
  // R3: a column step never disturbs the row fields
  a_r3_rows_kept: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_STEP_X |=> (cur_addr[14:11] == $past(cur_addr[14:11]) &&
                         cur_addr[9:5] == $past(cur_addr[9:5])));
endmodule

// File: rtl/scroll_addr_seq.sv
module scroll_addr_seq
  import scroll_pkg::*;
#(
  parameter int VISIBLE_LINES = 240,
  parameter int LINES = 262,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              render_en,
  input  logic [14:0]       tmp_addr,
  output logic [8:0]        dot,
  output logic [LINE_W-1:0] line,
  output logic [14:0]       cur_addr
);
  addr_op_e op;

  scroll_raster_counter #(.LINES(LINES)) u_counter (
    .clk  (clk),
    .rst_n(rst_n),
    .dot  (dot),
    .line (line)
  );

  scroll_op_decoder #(.VISIBLE_LINES(VISIBLE_LINES), .LINES(LINES)) u_decode (
    .dot      (dot),
    .line     (line),
    .render_en(render_en),
    .op       (op)
  );

  scroll_addr_reg u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .tmp_addr(tmp_addr),
    .cur_addr(cur_addr)
  );

  logic on_draw_line;
  assign on_draw_line = (line < LINE_W'(VISIBLE_LINES)) || (line == LINE_W'(LINES - 1));

  // R9: disabled rendering or a non-rendering line freezes the address
  a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en |=> cur_addr == $past(cur_addr));
  a_r9_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    !on_draw_line |=> cur_addr == $past(cur_addr));
  // R4: column wrap carries into the horizontal nametable bit
  a_r4_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (render_en && on_draw_line && dot == 9'd328 && cur_addr[4:0] == 5'd31)
    |=> (cur_addr[4:0] == 5'd0 && cur_addr[10] != $past(cur_addr[10])));
  // R6: row 29 flips the vertical nametable bit, row 31 does not
  a_r6_row29_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (render_en && on_draw_line && dot == 9'd256 && cur_addr[14:12] == 3'd7 &&
     cur_addr[9:5] == 5'd29)
    |=> (cur_addr[9:5] == 5'd0 && cur_addr[11] != $past(cur_addr[11])));
  a_r6_row31_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (render_en && on_draw_line && dot == 9'd256 && cur_addr[14:12] == 3'd7 &&
     cur_addr[9:5] == 5'd31)
    |=> (cur_addr[9:5] == 5'd0 && cur_addr[11] == $past(cur_addr[11])));
  // R7: horizontal reload at dot 257
  a_r7_horiz_load: assert property (@(posedge clk) disable iff (!rst_n)
    (render_en && on_draw_line && dot == 9'd257)
    |=> (cur_addr[10] == $past(tmp_addr[10]) && cur_addr[4:0] == $past(tmp_addr[4:0])));
endmodule

// File: tb/scroll_addr_seq_bench.sv
module scroll_addr_seq_bench;
  localparam int VIS = 2;
  localparam int LINES = 4;
  localparam int LW = $clog2(LINES);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          render_en = 1'b0;
  logic [14:0]   tmp_addr = '0;
  logic [8:0]    dot;
  logic [LW-1:0] line;
  logic [14:0]   cur_addr;

  int n_run = 0;
  int n_fail = 0;
  int e_dot = 0;
  int e_line = 0;
  logic [14:0] e_addr = '0;

  always #10 clk = ~clk;

  scroll_addr_seq #(.VISIBLE_LINES(VIS), .LINES(LINES)) u_scroll_addr_seq (
    .clk(clk), .rst_n(rst_n), .render_en(render_en), .tmp_addr(tmp_addr),
    .dot(dot), .line(line), .cur_addr(cur_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (dot %0d line %0d)", tag, act, exp, e_dot, e_line);
    end
  endtask

  function automatic bit is_draw(input int l);
    return (l < VIS) || (l == LINES - 1);
  endfunction

  function automatic bit is_col(input int d);
    return (d >= 8 && d <= 248 && d % 8 == 0) || d == 328 || d == 336;
  endfunction

  function automatic logic [14:0] ref_next(input int d, input int l, input logic en,
                                           input logic [14:0] a, input logic [14:0] t);
    logic [14:0] r;
    logic [5:0]  hx;
    int fy, cy;
    r = a;
    if (!en || !is_draw(l)) return a;
    if (is_col(d)) begin
      hx = {a[10], a[4:0]} + 6'd1;
      r[10] = hx[5];
      r[4:0] = hx[4:0];
    end else if (d == 256) begin
      fy = int'(a[14:12]);
      cy = int'(a[9:5]);
      if (fy < 7) fy++;
      else begin
        fy = 0;
        if (cy == 29) begin cy = 0; r[11] = ~a[11]; end
        else if (cy == 31) cy = 0;
        else cy++;
      end
      r[14:12] = 3'(fy);
      r[9:5] = 5'(cy);
    end else if (d == 257) begin
      r[10] = t[10];
      r[4:0] = t[4:0];
    end else if (l == LINES - 1 && d >= 280 && d <= 304) begin
      r[14:11] = t[14:11];
      r[9:5] = t[9:5];
    end
    return r;
  endfunction

  function automatic string ref_tag(input int d, input int l, input logic en);
    if (!en || !is_draw(l)) return "R9";
    if (d == 256) return "R5/R6";
    if (d == 257) return "R7";
    if (is_col(d)) return "R3/R4";
    if (l == LINES - 1 && d >= 280 && d <= 304) return "R8";
    return "R9";
  endfunction

  // one clock: predict, step, compare at the falling edge
  task automatic step();
    logic [14:0] nx;
    string tag;
    nx = ref_next(e_dot, e_line, render_en, e_addr, tmp_addr);
    tag = ref_tag(e_dot, e_line, render_en);
    @(posedge clk);
    @(negedge clk);
    e_addr = nx;
    if (e_dot == 340) begin
      e_dot = 0;
      e_line = (e_line == LINES - 1) ? 0 : e_line + 1;
    end else e_dot++;
    chk(tag, int'(cur_addr), int'(e_addr));
    chk("R2 dot", int'(dot), e_dot);
    chk("R2 line", int'(line), e_line);
  endtask

  task automatic run_to(input int d, input int l);
    while (!(e_dot == d && e_line == l)) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [14:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 dot", int'(dot), 0);
    chk("R1 line", int'(line), 0);
    chk("R1 addr", int'(cur_addr), 0);
    rst_n = 1'b1;
    render_en = 1'b1;
    tmp_addr = '0;
    step();
    chk("R1 addr after release", int'(cur_addr), 0);

    // line 0 from zero: 31 column steps, then one fine row step
    run_to(257, 0);
    chk("R3/R5 end of fetch", int'(cur_addr), 'h101F);
    step();
    chk("R7 reload", int'(cur_addr), 'h1000);
    run_to(337, 0);
    chk("R3 prefetch steps", int'(cur_addr), 'h1002);

    // column wrap during prefetch of line 1
    run_to(257, 1);
    tmp_addr = 15'h001E;
    run_to(337, 1);
    chk("R4 column wrap", int'(cur_addr), 'h2400);

    // idle line holds with rendering on
    run_to(0, 2);
    held = cur_addr;
    run_to(0, 3);
    chk("R9 idle line", int'(cur_addr), int'(held));

    // row 29 wrap loaded through the pre-render copy
    tmp_addr = 15'h73A0;
    run_to(305, 3);
    chk("R8 vert copy hi", int'(cur_addr[14:11]), 'hE);
    chk("R8 vert copy row", int'(cur_addr[9:5]), 29);
    run_to(257, 0);
    chk("R6 row29 hi", int'(cur_addr[14:11]), 'h1);
    chk("R6 row29 row", int'(cur_addr[9:5]), 0);

    // row 31 wrap keeps the vertical nametable bit
    run_to(250, 3);
    tmp_addr = 15'h73E0;
    run_to(257, 0);
    chk("R6 row31 hi", int'(cur_addr[14:11]), 'h0);
    chk("R6 row31 row", int'(cur_addr[9:5]), 0);

    // rendering off for a full line
    run_to(0, 1);
    render_en = 1'b0;
    held = cur_addr;
    run_to(0, 2);
    chk("R9 disabled line", int'(cur_addr), int'(held));

    // random frames with targeted row wraps
    run_to(0, 0);
    for (int f = 0; f < 50; f++) begin
      for (int l = 0; l < LINES; l++) begin
        render_en = ($urandom % 4) != 0;
        tmp_addr = 15'($urandom);
        if (l == LINES - 1 && ($urandom % 3) == 0) begin
          tmp_addr[14:12] = 3'd7;
          tmp_addr[9:5] = ($urandom % 2) ? 5'd29 : 5'd31;
        end
        for (int d = 0; d < 341; d++) begin
          if (($urandom % 300) == 0) render_en = ~render_en;
          step();
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule